// File: doc/BRIEF.md
# Soft-Output Update Array

This block produces the soft input for the next half-iteration of a product-code decoder. A row of identical lanes, one per bit position of a component codeword, each take the received channel value and the previous soft value for their bit, together with the hard bit of the word that was decided for the row. Each lane works out a reliability for that decision. No competing codeword is kept, so the reliability is always an estimate built from the bit's own magnitude, the sum of the least reliable magnitudes and the winning metric. The lane subtracts the previous soft value to get the extrinsic term. It damps that term by a power of two and adds it back onto the channel value.

Every value is held in sign-magnitude form. Damping is a right shift of the magnitude. The final sum clips at the largest magnitude a soft value can hold. A single register stage holds the whole row, and the row is updated every clock. The metric terms and the damping code are shared by all lanes.

Top module: `soft_out_unit`

## Requirements
- R1: Synchronous active-high reset clears every output lane to zero. A new result appears on `soft_o` exactly one rising clock edge after its inputs are applied, and it does not appear before that edge.
- R2: The reliability magnitude is F = |R′| + `lr_sum_i` − `min_metric_i`. It is clamped below at 0 and above at 2^(Q−1)−1. F carries a negative sign when the lane's decided bit is 1 and a positive sign when it is 0.
- R3: The extrinsic term is W = F − R′. It is computed as a signed sum with no loss of range.
- R4: `damp_i` = d (0..3) scales W by 2^−d. This is done by shifting |W| right by d bits, which truncates toward zero, and the sign is kept.
- R5: The lane output is R + damped W, saturated to ±(2^(Q−1)−1). The output never wraps.
- R6: A zero result is always driven with a positive sign bit.
- R7: Soft values are Q bits wide. Bit Q−1 is the sign (1 = negative) and the low Q−1 bits are the magnitude. An input with a set sign and zero magnitude is treated as zero. Lane i occupies bits [i·Q +: Q] of each packed bus, and bit i of `hard_i`.
- R8: Lanes are independent of each other. Only `lr_sum_i`, `min_metric_i` and `damp_i` are shared across the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_i | input | NB*Q | Packed channel values, sign-magnitude |
| prev_i | input | NB*Q | Packed previous soft values, sign-magnitude |
| hard_i | input | NB | Decided-word hard bits, one per lane |
| min_metric_i | input | MW | Metric of the decided word, unsigned |
| lr_sum_i | input | MW | Sum of least reliable magnitudes, unsigned |
| damp_i | input | 2 | Damping code d, scale factor 2^−d |
| soft_o | output | NB*Q | Registered next soft values, sign-magnitude |

## Verification
The bench builds the block with four lanes, Q = 5 and MW = 6. This keeps each lane's input space small: all 32 codes of the channel value and all 32 codes of the previous value, both decided-bit values and all four damping codes. That space is swept in full, once for each of eight metric pairs. The pairs drive the reliability to zero, into its upper clamp and through the middle of its range. Each lane is fed a different rotation of the sweep. Because of this, a fault that couples lanes or misplaces a field shows up, as do both negative-zero encodings and every saturation corner.

// File: rtl/soft_pkg.sv
package soft_pkg;

    // Internal magnitude width, wide enough for metric sums and the extrinsic term.
    localparam int IW = 10;

    typedef struct packed {
        logic          neg;
        logic [IW-1:0] mag;
    } smag_t;

    typedef enum logic [1:0] {
        DAMP_ONE     = 2'd0,
        DAMP_HALF    = 2'd1,
        DAMP_QUARTER = 2'd2,
        DAMP_EIGHTH  = 2'd3
    } damp_e;

    // Force a zero magnitude to carry a positive sign.
    function automatic smag_t sm_norm(smag_t a);
        smag_t r;
        r = a;
        if (a.mag == '0) r.neg = 1'b0;
        return r;
    endfunction

    function automatic smag_t sm_neg(smag_t a);
        smag_t r;
        r.neg = ~a.neg;
        r.mag = a.mag;
        return sm_norm(r);
    endfunction

    // Sign-magnitude addition: same signs add, opposite signs subtract smaller from larger.
    function automatic smag_t sm_add(smag_t a, smag_t b);
        smag_t r;
        if (a.neg == b.neg) begin
            r.neg = a.neg;
            r.mag = a.mag + b.mag;
        end else if (a.mag >= b.mag) begin
            r.neg = a.neg;
            r.mag = a.mag - b.mag;
        end else begin
            r.neg = b.neg;
            r.mag = b.mag - a.mag;
        end
        return sm_norm(r);
    endfunction

    // Clip a magnitude at lim, keeping the sign.
    function automatic smag_t sm_sat(smag_t a, logic [IW-1:0] lim);
        smag_t r;
        r.neg = a.neg;
        r.mag = (a.mag > lim) ? lim : a.mag;
        return sm_norm(r);
    endfunction

    // Widen a Q-bit sign-magnitude code (Q <= IW+1).
    function automatic smag_t sm_from_code(logic [IW:0] code, int q);
        smag_t r;
        logic [IW-1:0] m;
        m = '0;
        for (int i = 0; i < IW; i++) begin
            if (i < q - 1) m[i] = code[i];
        end
        r.neg = code[q-1];
        r.mag = m;
        return sm_norm(r);
    endfunction

endpackage

// File: rtl/so_offset.sv
module so_offset
    import soft_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic [MW-1:0] lr_sum,
    input  logic [MW-1:0] min_metric,
    output smag_t         offset
);
    smag_t lr_s, mm_s;

    always_comb begin
        lr_s.neg = 1'b0;
        lr_s.mag = IW'(lr_sum);
        mm_s.neg = 1'b1;
        mm_s.mag = IW'(min_metric);
        offset   = sm_add(lr_s, sm_norm(mm_s));
    end
endmodule

// File: rtl/so_lane.sv
module so_lane
    import soft_pkg::*;
#(
    parameter int Q = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [Q-1:0] chan,
    input  logic [Q-1:0] prev,
    input  logic         hard,
    input  smag_t        offset,
    input  damp_e        damp,
    output logic [Q-1:0] nxt
);
    localparam int MB = Q - 1;
    localparam logic [IW-1:0] LIM = IW'((1 << MB) - 1);

    smag_t chan_s, prev_s, rsum, rel, extr, damped, total;
    logic [IW-1:0] rel_mag;

    always_comb begin
        chan_s  = sm_from_code((IW+1)'(chan), Q);
        prev_s  = sm_from_code((IW+1)'(prev), Q);

        // Reliability estimate: |R'| plus (least-reliable sum minus min metric).
        rsum    = sm_add('{neg: 1'b0, mag: prev_s.mag}, offset);
        rel_mag = rsum.neg ? '0 : ((rsum.mag > LIM) ? LIM : rsum.mag);
        rel     = sm_norm('{neg: hard, mag: rel_mag});

        // Extrinsic term and power-of-two damping on the magnitude.
        extr    = sm_add(rel, sm_neg(prev_s));
        damped  = sm_norm('{neg: extr.neg, mag: extr.mag >> damp});

        total   = sm_sat(sm_add(chan_s, damped), LIM);
        nxt     = {total.neg, total.mag[MB-1:0]};
    end

    assert_rel_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (rel.mag <= LIM) && ((rel.mag != '0) -> (rel.neg == hard)));

    assert_damp_shrink_R4: assert property (@(posedge clk) disable iff (rst)
        (damped.mag <= extr.mag) && ((damped.mag != '0) -> (damped.neg == extr.neg)));

    assert_damp_unity_R4: assert property (@(posedge clk) disable iff (rst)
        (damp == DAMP_ONE) -> (damped == extr));
endmodule

// File: rtl/soft_out_unit.sv
module soft_out_unit
    import soft_pkg::*;
#(
    parameter int NB = 32,
    parameter int Q  = 5,
    parameter int MW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB*Q-1:0] chan_i,
    input  logic [NB*Q-1:0] prev_i,
    input  logic [NB-1:0]   hard_i,
    input  logic [MW-1:0]   min_metric_i,
    input  logic [MW-1:0]   lr_sum_i,
    input  logic [1:0]      damp_i,
    output logic [NB*Q-1:0] soft_o
);
    localparam int MB = Q - 1;

    smag_t           offset;
    damp_e           damp;
    logic [NB*Q-1:0] nxt_all;
    logic [NB*Q-1:0] soft_q;

    assign damp = damp_e'(damp_i);

    so_offset #(.MW(MW)) u_off (
        .lr_sum     (lr_sum_i),
        .min_metric (min_metric_i),
        .offset     (offset)
    );

    for (genvar g = 0; g < NB; g++) begin : g_lane
        so_lane #(.Q(Q)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .chan   (chan_i[g*Q +: Q]),
            .prev   (prev_i[g*Q +: Q]),
            .hard   (hard_i[g]),
            .offset (offset),
            .damp   (damp),
            .nxt    (nxt_all[g*Q +: Q])
        );

        assert_zero_pos_R6: assert property (@(posedge clk) disable iff (rst)
            soft_q[g*Q +: MB] == '0 |-> !soft_q[g*Q + MB]);
    end

    always_ff @(posedge clk) begin
        if (rst) soft_q <= '0;
        else     soft_q <= nxt_all;
    end

    assign soft_o = soft_q;
endmodule

// File: tb/sim_soft_out_unit.sv
module sim_soft_out_unit;
    localparam int NB = 4;
    localparam int Q  = 5;
    localparam int MW = 6;
    localparam int MB = Q - 1;
    localparam int LIM = (1 << MB) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB*Q-1:0] chan_i = '0;
    logic [NB*Q-1:0] prev_i = '0;
    logic [NB-1:0]   hard_i = '0;
    logic [MW-1:0]   min_metric_i = '0;
    logic [MW-1:0]   lr_sum_i = '0;
    logic [1:0]      damp_i = '0;
    logic [NB*Q-1:0] soft_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    soft_out_unit #(.NB(NB), .Q(Q), .MW(MW)) u0 (
        .clk(clk), .rst(rst), .chan_i(chan_i), .prev_i(prev_i), .hard_i(hard_i),
        .min_metric_i(min_metric_i), .lr_sum_i(lr_sum_i), .damp_i(damp_i), .soft_o(soft_o)
    );

    // R7: bit Q-1 sign, low bits magnitude; negative zero decodes to 0.
    function automatic int dec(logic [Q-1:0] c);
        int m;
        m = int'(c[MB-1:0]);
        return c[Q-1] ? -m : m;
    endfunction

    function automatic logic [Q-1:0] enc(int v);
        logic [Q-1:0] r;
        if (v < 0) r = {1'b1, MB'(-v)};
        else       r = {1'b0, MB'(v)};
        return r;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Arithmetic model of R2..R5.
    function automatic int model(logic [Q-1:0] ch, logic [Q-1:0] pv, logic h,
                                 int lr, int mm, int d, output int raw);
        int f, fs, w, wm, ws, o;
        f = iabs(dec(pv)) + lr - mm;
        if (f < 0) f = 0;
        if (f > LIM) f = LIM;
        fs = h ? -f : f;
        w  = fs - dec(pv);
        wm = iabs(w) >> d;
        ws = (w < 0) ? -wm : wm;
        o  = dec(ch) + ws;
        raw = o;
        if (o > LIM) o = LIM;
        if (o < -LIM) o = -LIM;
        return o;
    endfunction

    task automatic check_lane(int k, logic [Q-1:0] exp_code, string tag);
        checks++;
        if (soft_o[k*Q +: Q] !== exp_code) begin
            errors++;
            $display("FAIL %s lane %0d: got %b expected %b", tag, k, soft_o[k*Q +: Q], exp_code);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int mm_tab [8] = '{0, 0, 5, 0, 63, 7, 20, 63};
        int lr_tab [8] = '{0, 5, 0, 63, 0, 20, 7, 63};
        logic [Q-1:0] exp_c [NB];
        logic [Q-1:0] last_c [NB];

        // R1: reset clears all lanes.
        chan_i = {NB{5'b00111}};
        prev_i = {NB{5'b10011}};
        hard_i = '1;
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NB; k++) check_lane(k, '0, "R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R1: result appears only after the next rising edge.
        lr_sum_i = 6'd10;
        min_metric_i = 6'd2;
        damp_i = 2'd0;
        @(posedge clk);
        #1;
        for (int k = 0; k < NB; k++) begin
            int raw;
            last_c[k] = enc(model(chan_i[k*Q +: Q], prev_i[k*Q +: Q], hard_i[k], 10, 2, 0, raw));
            check_lane(k, last_c[k], "R1 first result");
        end
        @(negedge clk);
        chan_i = {NB{5'b01111}};
        prev_i = {NB{5'b00000}};
        hard_i = '0;
        #1;
        for (int k = 0; k < NB; k++) check_lane(k, last_c[k], "R1 hold before edge");

        // Sweep: every chan/prev code, both hard bits, every damping code, eight metric pairs.
        for (int mp = 0; mp < 8; mp++) begin
            for (int c = 0; c < 32; c++) begin
                for (int p = 0; p < 32; p++) begin
                    for (int h = 0; h < 2; h++) begin
                        for (int d = 0; d < 4; d++) begin
                            @(negedge clk);
                            lr_sum_i     = MW'(lr_tab[mp]);
                            min_metric_i = MW'(mm_tab[mp]);
                            damp_i       = 2'(d);
                            for (int k = 0; k < NB; k++) begin
                                int raw;
                                // R8: each lane gets its own rotation of the sweep.
                                chan_i[k*Q +: Q] = Q'((c + 7 * k) % 32);
                                prev_i[k*Q +: Q] = Q'((p + 13 * k) % 32);
                                hard_i[k]        = 1'(h) ^ 1'(k);
                                exp_c[k] = enc(model(chan_i[k*Q +: Q], prev_i[k*Q +: Q], hard_i[k],
                                                     lr_tab[mp], mm_tab[mp], d, raw));
                            end
                            @(posedge clk);
                            #1;
                            for (int k = 0; k < NB; k++) begin
                                int raw;
                                int o;
                                string tag;
                                o = model(chan_i[k*Q +: Q], prev_i[k*Q +: Q], hard_i[k],
                                          lr_tab[mp], mm_tab[mp], d, raw);
                                if (o == 0)            tag = "R6 zero sign";
                                else if (iabs(raw) > LIM) tag = "R5 saturation";
                                else if (d != 0)       tag = "R4 damping";
                                else                   tag = "R2 R3 reliability extrinsic";
                                check_lane(k, exp_c[k], {tag, " R8"});
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule